// File: doc/BRIEF.md
# Behavioural NAND Page Array with Bit-Clearing Program

This block models a small NAND flash array inside a chip. Every page carries a main data area and a spare area one thirty-second of its size, so a 256-byte page has 264 bytes in all. All traffic goes through a single page register. A load copies stored bytes from a chosen column to the end of the page into the register. The front end then reads them out one byte at a time. A program merges the register contents into a stored page with a bitwise AND, so programming can only clear bits. An erase of a block of pages is the only way to bring bytes back to 0xFF.

The front end raises `req_valid` for one cycle with an opcode, a page and a column. The block answers every request with a one-cycle `done`, and `fail` rides on that same cycle. Bytes for a program are pushed into the page register beforehand with `wr_en`. Reads advance with `rd_en` and count `bytes_left` down. Once a loaded page is used up, the next read starts a load of the following page, so a stream of reads runs on across page boundaries.

The controller is a five-state machine:
- IDLE accepts requests, register writes and reads.
- LOAD copies one byte per cycle into the page register.
- PROG merges one byte per cycle into the array.
- ERASE fills one byte per cycle of the aligned block with 0xFF.
- DONE raises `done` and returns to IDLE.

The transitions are:
- IDLE to LOAD on a valid load request, or on a read that finds no bytes left after a load.
- IDLE to PROG on an in-range program with buffered bytes.
- IDLE to ERASE on an in-range erase.
- IDLE straight to DONE on an out-of-range, empty or unknown request.
- LOAD, PROG and ERASE to DONE after their last byte.
- DONE to IDLE.

Top module: `nand_page_array`

## Requirements
- R1: After reset every stored byte reads back as 0xFF, `done` is low, `bytes_left` is 0 and `rd_data` is 0.
- R2: The spare area is PAGE_BYTES>>5 bytes, so a load at column 0 of the default 256-byte page sets `bytes_left` to 264. A page size other than 256, 512 or 2048 stops elaboration.
- R3: A program (opcode 1) stores the AND of the old byte and the page-register byte, so a second program can only clear further bits.
- R4: A program writes page-register byte i to column `req_col`+i. Bytes whose column would fall past the page's last byte are dropped.
- R5: The page register accepts at most one page plus spare of bytes between programs. Further `wr_en` bytes are dropped. The buffer empties after every program request and every load.
- R6: An erase (opcode 2) aligns the page index down to a multiple of 2^BLOCK_SHIFT and sets every byte of those pages to 0xFF.
- R7: A request whose page index is NUM_PAGES or above changes no stored byte and completes with `fail` high. In-range requests complete with `fail` low. A load at such a page, or at a column past the page, leaves `bytes_left` at 0.
- R8: A load (opcode 0) sets `bytes_left` to page-plus-spare minus `req_col`, and the first byte read is the stored byte at `req_col`.
- R9: Each cycle with `rd_en` high, `ce_n` low and `bytes_left` nonzero moves to the next byte and lowers `bytes_left` by one.
- R10: A read with `ce_n` low while `bytes_left` is 0 after a load loads the next page from column 0 (wrapping from the last page to page 0) and pulses `done`.
- R11: While `ce_n` is high, `rd_data` is 0 and reads and writes do not advance. `rd_data` is also 0 when no bytes remain.
- R12: Every request, including the unused opcode 3 (which fails), yields `done` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken in IDLE |
| req_op | input | 2 | 0 load, 1 program, 2 erase, 3 unused |
| req_page | input | PW | Page index, one bit wider than needed for NUM_PAGES |
| req_col | input | CW | Starting column within the page |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Request failed, valid with `done` |
| ce_n | input | 1 | Chip enable for the byte port, active low |
| wr_en | input | 1 | Push `wr_data` into the page register |
| wr_data | input | 8 | Byte to buffer for a program |
| rd_en | input | 1 | Advance to the next read byte |
| rd_data | output | 8 | Current page-register byte |
| bytes_left | output | CW | Bytes remaining in the loaded page |

## Verification
The bench programs one page twice with overlapping patterns. A design that overwrote instead of ANDing would leave the second pattern intact. It programs at a column near the page end and overflows the page register. A design that wrapped the column or the buffer index would corrupt the low bytes. It erases an odd page and expects its even partner cleared too, which catches missing block alignment. It drives reads across a page end and off the last page, where a design without auto-load would keep returning zero and one without wrap would fail the load. It also checks that out-of-range requests and chip-disabled reads leave both the array and the read position untouched.

// File: rtl/nand_pkg.sv
package nand_pkg;

    typedef enum logic [1:0] {
        OP_LOAD    = 2'd0,
        OP_PROGRAM = 2'd1,
        OP_ERASE   = 2'd2,
        OP_NONE    = 2'd3
    } nand_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG,
        ST_ERASE,
        ST_DONE
    } nand_state_e;

endpackage

// File: rtl/nand_ram.sv
module nand_ram #(
    parameter int DEPTH = 16,
    parameter int AW = 4,
    parameter logic [7:0] FILL = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= FILL;
        end else if (we && (32'(waddr) < DEPTH)) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = (32'(raddr) < DEPTH) ? cells[raddr] : FILL;
endmodule

// File: rtl/nand_addr_gen.sv
module nand_addr_gen #(
    parameter int PAGE_TOTAL = 264,
    parameter int BLOCK_SHIFT = 1,
    parameter int PW = 3,
    parameter int CW = 9,
    parameter int IW = 10,
    parameter int MAW = 11
) (
    input  logic [PW-1:0]  page,
    input  logic [CW-1:0]  col,
    input  logic [IW-1:0]  idx,
    input  logic           whole_block,
    output logic [MAW-1:0] addr,
    output logic           in_page
);
    logic [31:0] blk_page;

    always_comb begin
        blk_page = (32'(page) >> BLOCK_SHIFT) << BLOCK_SHIFT;
        if (whole_block)
            addr = MAW'(blk_page * PAGE_TOTAL + 32'(idx));
        else
            addr = MAW'(32'(page) * PAGE_TOTAL + 32'(col) + 32'(idx));
        in_page = (32'(col) + 32'(idx)) < PAGE_TOTAL;
    end
endmodule

// File: rtl/nand_page_array.sv
module nand_page_array
    import nand_pkg::*;
#(
    parameter int PAGE_BYTES  = 256,
    parameter int NUM_PAGES   = 4,
    parameter int BLOCK_SHIFT = 1,
    localparam int TOTAL      = PAGE_BYTES + (PAGE_BYTES >> 5),
    localparam int CW         = $clog2(TOTAL + 1),
    localparam int PW         = $clog2(NUM_PAGES) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [PW-1:0] req_page,
    input  logic [CW-1:0] req_col,
    output logic          done,
    output logic          fail,
    input  logic          ce_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] bytes_left
);
    localparam int PAW       = $clog2(TOTAL);
    localparam int MEM_DEPTH = NUM_PAGES * TOTAL;
    localparam int MAW       = $clog2(MEM_DEPTH);
    localparam int BLK_BYTES = TOTAL << BLOCK_SHIFT;
    localparam int IW        = $clog2(BLK_BYTES + 1);

    generate
        if (PAGE_BYTES != 256 && PAGE_BYTES != 512 && PAGE_BYTES != 2048) begin : g_bad_page
            $error("nand_page_array: PAGE_BYTES must be 256, 512 or 2048");
        end
    endgenerate

    nand_state_e state, state_nx;
    nand_op_e    op_in;
    logic [IW-1:0]  idx, op_len;
    logic [PW-1:0]  cur_page;
    logic [CW-1:0]  cur_col, left, wr_cnt;
    logic [PAW-1:0] ptr;
    logic           fail_q, rd_mode;

    logic           in_idle, page_ok, col_ok_req, last;
    logic           auto_load, read_step, wr_take;
    logic           store_we, preg_we, whole_block, in_page;
    logic [MAW-1:0] store_addr;
    logic [7:0]     store_q, store_wd, preg_q, preg_wd;
    logic [PAW-1:0] preg_wa, preg_ra;

    assign op_in      = nand_op_e'(req_op);
    assign in_idle    = (state == ST_IDLE);
    assign page_ok    = 32'(req_page) < NUM_PAGES;
    assign col_ok_req = 32'(req_col) < TOTAL;
    assign last       = (idx == op_len - 1'b1);
    assign auto_load  = in_idle && !req_valid && !ce_n && rd_en && (left == '0) && rd_mode;
    assign read_step  = in_idle && !req_valid && !ce_n && rd_en && (left != '0);
    assign wr_take    = in_idle && !req_valid && !ce_n && wr_en && (wr_cnt < CW'(TOTAL));

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    case (op_in)
                        OP_LOAD:    state_nx = (page_ok && col_ok_req) ? ST_LOAD : ST_DONE;
                        OP_PROGRAM: state_nx = (page_ok && wr_cnt != '0) ? ST_PROG : ST_DONE;
                        OP_ERASE:   state_nx = page_ok ? ST_ERASE : ST_DONE;
                        default:    state_nx = ST_DONE;
                    endcase
                end else if (auto_load) begin
                    state_nx = ST_LOAD;
                end
            end
            ST_LOAD, ST_PROG, ST_ERASE: if (last) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            op_len   <= '0;
            cur_page <= '0;
            cur_col  <= '0;
            left     <= '0;
            wr_cnt   <= '0;
            ptr      <= '0;
            fail_q   <= 1'b0;
            rd_mode  <= 1'b0;
        end else begin
            state <= state_nx;
            if (in_idle && req_valid) begin
                idx      <= '0;
                left     <= '0;
                ptr      <= '0;
                cur_page <= req_page;
                cur_col  <= req_col;
                fail_q   <= !page_ok || (op_in == OP_NONE) || (op_in == OP_LOAD && !col_ok_req);
                case (op_in)
                    OP_LOAD: begin
                        rd_mode <= 1'b1;
                        wr_cnt  <= '0;
                        op_len  <= IW'(TOTAL) - IW'(req_col);
                    end
                    OP_PROGRAM: begin
                        rd_mode <= 1'b0;
                        wr_cnt  <= '0;
                        op_len  <= IW'(wr_cnt);
                    end
                    OP_ERASE: begin
                        rd_mode <= 1'b0;
                        op_len  <= IW'(BLK_BYTES);
                    end
                    default: ;
                endcase
            end else if (auto_load) begin
                idx      <= '0;
                fail_q   <= 1'b0;
                cur_page <= (cur_page == PW'(NUM_PAGES - 1)) ? '0 : cur_page + 1'b1;
                cur_col  <= '0;
                op_len   <= IW'(TOTAL);
                wr_cnt   <= '0;
            end else begin
                if (read_step) begin
                    ptr  <= ptr + 1'b1;
                    left <= left - 1'b1;
                end
                if (wr_take) wr_cnt <= wr_cnt + 1'b1;
                if (state == ST_LOAD || state == ST_PROG || state == ST_ERASE) begin
                    idx <= idx + 1'b1;
                    if (state == ST_LOAD && last) begin
                        left <= CW'(op_len);
                        ptr  <= '0;
                    end
                end
            end
        end
    end

    // Outputs and memory controls
    always_comb begin
        done        = (state == ST_DONE);
        fail        = done && fail_q;
        bytes_left  = left;
        rd_data     = (in_idle && !ce_n && left != '0) ? preg_q : 8'h00;
        whole_block = (state == ST_ERASE);
        store_we    = (state == ST_PROG && in_page) || (state == ST_ERASE);
        store_wd    = (state == ST_ERASE) ? 8'hFF : (store_q & preg_q);
        preg_we     = (state == ST_LOAD) || wr_take;
        preg_wa     = (state == ST_LOAD) ? idx[PAW-1:0] : wr_cnt[PAW-1:0];
        preg_wd     = (state == ST_LOAD) ? store_q : wr_data;
        preg_ra     = (state == ST_PROG) ? idx[PAW-1:0] : ptr;
    end

    nand_addr_gen #(
        .PAGE_TOTAL(TOTAL), .BLOCK_SHIFT(BLOCK_SHIFT),
        .PW(PW), .CW(CW), .IW(IW), .MAW(MAW)
    ) u_addr (
        .page(cur_page), .col(cur_col), .idx(idx),
        .whole_block(whole_block), .addr(store_addr), .in_page(in_page)
    );

    nand_ram #(.DEPTH(MEM_DEPTH), .AW(MAW), .FILL(8'hFF)) u_store (
        .clk(clk), .rst_n(rst_n), .we(store_we), .waddr(store_addr),
        .wdata(store_wd), .raddr(store_addr), .rdata(store_q)
    );

    nand_ram #(.DEPTH(TOTAL), .AW(PAW), .FILL(8'hFF)) u_pagereg (
        .clk(clk), .rst_n(rst_n), .we(preg_we), .waddr(preg_wa),
        .wdata(preg_wd), .raddr(preg_ra), .rdata(preg_q)
    );
endmodule

// File: rtl/nand_page_array_chk.sv
module nand_page_array_chk #(
    parameter int PAGE_BYTES = 256,
    localparam int TOTAL = PAGE_BYTES + (PAGE_BYTES >> 5),
    localparam int CW = $clog2(TOTAL + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          ce_n,
    input logic          rd_en,
    input logic          done,
    input logic          in_idle,
    input logic [7:0]    rd_data,
    input logic [CW-1:0] bytes_left,
    input logic [CW-1:0] wr_cnt
);
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_left_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bytes_left <= CW'(TOTAL));

    assert_buffer_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= CW'(TOTAL));

    assert_ce_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> rd_data == 8'h00);

    assert_ce_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && in_idle && !req_valid) |=> $stable(bytes_left));

    assert_read_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && in_idle && !req_valid && rd_en && bytes_left != '0)
        |=> bytes_left == $past(bytes_left) - 1'b1);
endmodule

bind nand_page_array nand_page_array_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ce_n(ce_n),
    .rd_en(rd_en), .done(done), .in_idle(in_idle), .rd_data(rd_data),
    .bytes_left(bytes_left), .wr_cnt(wr_cnt)
);

// File: tb/nand_page_array_test.sv
module nand_page_array_test;
    localparam int CLK_PERIOD = 10;
    localparam int PB = 256;
    localparam int NP = 4;
    localparam int BS = 1;
    localparam int T  = PB + PB / 32;
    localparam int CW = $clog2(T + 1);
    localparam int PW = $clog2(NP) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [PW-1:0] req_page = '0;
    logic [CW-1:0] req_col = '0;
    logic done, fail;
    logic ce_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [CW-1:0] bytes_left;

    logic [7:0] ref_mem [NP*T];
    logic [7:0] wbuf [T];
    int wcount = 0;
    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_page_array #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .BLOCK_SHIFT(BS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_page(req_page), .req_col(req_col), .done(done), .fail(fail),
        .ce_n(ce_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .bytes_left(bytes_left)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic issue(input int op, input int page, input int col, output bit f);
        @(negedge clk);
        req_valid = 1'b1;
        req_op = 2'(op);
        req_page = PW'(page);
        req_col = CW'(col);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        f = fail;
        @(negedge clk);
        chk(!done, "R12 done one cycle", int'(done), 0);
    endtask

    task automatic push(input int n, input int start, input int step);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = 8'(start + i * step);
            if (wcount < T) begin
                wbuf[wcount] = 8'(start + i * step);
                wcount++;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic m_program(input int p, input int c);
        if (p < NP)
            for (int i = 0; i < wcount; i++)
                if (c + i < T) ref_mem[p*T + c + i] = ref_mem[p*T + c + i] & wbuf[i];
        wcount = 0;
    endtask

    task automatic m_erase(input int p);
        int base;
        if (p < NP) begin
            base = (p >> BS) << BS;
            for (int q = base; q < base + (1 << BS); q++)
                for (int i = 0; i < T; i++) ref_mem[q*T + i] = 8'hFF;
        end
    endtask

    task automatic read_cmp(input int p, input int c, input int n, input string req);
        int bad = 0;
        int act = 0;
        int exp = 0;
        for (int i = 0; i < n; i++) begin
            if (rd_data !== ref_mem[p*T + c + i] && bad == 0) begin
                bad = 1;
                act = int'(rd_data);
                exp = int'(ref_mem[p*T + c + i]);
            end
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        chk(bad == 0, req, act, exp);
    endtask

    task automatic expect_page(input int p, input int c, input string req);
        bit f;
        issue(0, p, c, f);
        wcount = 0;
        chk(f == 1'b0, "R7 in-range load fail low", int'(f), 0);
        chk(int'(bytes_left) == T - c, "R8 bytes left after load", int'(bytes_left), T - c);
        read_cmp(p, c, T - c, req);
    endtask

    task automatic do_program(input int p, input int c, input string req);
        bit f;
        issue(1, p, c, f);
        chk(f == (p >= NP), req, int'(f), int'(p >= NP));
        m_program(p, c);
    endtask

    task automatic t_reset();
        chk(done == 1'b0, "R1 done low after reset", int'(done), 0);
        chk(bytes_left == '0, "R1 bytes_left zero after reset", int'(bytes_left), 0);
        chk(rd_data == 8'h00, "R1 rd_data zero after reset", int'(rd_data), 0);
        expect_page(3, 0, "R1 erased contents");
        chk(T == 264, "R2 page plus spare", T, 264);
    endtask

    task automatic t_and();
        push(T, 8'h5A, 7);
        do_program(1, 0, "R7 program fail low");
        expect_page(1, 0, "R3 first program");
        push(T, 0, 3);
        do_program(1, 0, "R7 program fail low");
        expect_page(1, 0, "R3 second program ANDs");
    endtask

    task automatic t_col();
        push(20, 8'h33, 11);
        do_program(0, 250, "R7 program fail low");
        expect_page(0, 0, "R4 column start and clip");
    endtask

    task automatic t_overflow();
        push(T, 1, 5);
        push(6, 0, 0);
        do_program(2, 0, "R7 program fail low");
        expect_page(2, 0, "R5 extra bytes dropped");
    endtask

    task automatic t_seq();
        bit f;
        issue(0, 1, 260, f);
        chk(int'(bytes_left) == 4, "R8 offset load count", int'(bytes_left), 4);
        read_cmp(1, 260, 4, "R9 tail bytes");
        chk(rd_data == 8'h00, "R11 no bytes left reads zero", int'(rd_data), 0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        wait_done();
        @(negedge clk);
        chk(int'(bytes_left) == T, "R10 next page loaded", int'(bytes_left), T);
        read_cmp(2, 0, 8, "R10 next page data");
        issue(0, 3, 263, f);
        read_cmp(3, 263, 1, "R9 last byte");
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        wait_done();
        @(negedge clk);
        read_cmp(0, 0, 8, "R10 wrap to page 0");
        wcount = 0;
    endtask

    task automatic t_range();
        bit f;
        push(4, 0, 0);
        do_program(4, 0, "R7 out-of-range program fails");
        issue(2, 5, 0, f);
        chk(f == 1'b1, "R7 out-of-range erase fails", int'(f), 1);
        issue(0, 6, 0, f);
        chk(f == 1'b1, "R7 out-of-range load fails", int'(f), 1);
        chk(bytes_left == '0, "R7 failed load leaves zero", int'(bytes_left), 0);
        expect_page(0, 0, "R7 array unchanged");
    endtask

    task automatic t_erase();
        bit f;
        push(T, 0, 0);
        do_program(3, 0, "R7 program fail low");
        expect_page(3, 0, "R3 cleared page");
        issue(2, 3, 0, f);
        chk(f == 1'b0, "R7 in-range erase fail low", int'(f), 0);
        m_erase(3);
        expect_page(2, 0, "R6 aligned partner erased");
        expect_page(3, 0, "R6 target erased");
        expect_page(1, 0, "R6 other block kept");
    endtask

    task automatic t_ce();
        bit f;
        issue(0, 1, 0, f);
        ce_n = 1'b1;
        #1;
        chk(rd_data == 8'h00, "R11 ce_n high reads zero", int'(rd_data), 0);
        rd_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        ce_n = 1'b0;
        #1;
        chk(int'(bytes_left) == T, "R11 no advance while disabled", int'(bytes_left), T);
        chk(rd_data == ref_mem[T], "R11 read position kept", int'(rd_data), int'(ref_mem[T]));
    endtask

    task automatic t_done();
        bit f;
        issue(3, 0, 0, f);
        chk(f == 1'b1, "R12 unused opcode fails", int'(f), 1);
    endtask

    initial begin
        for (int i = 0; i < NP*T; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_and();
        t_col();
        t_overflow();
        t_seq();
        t_range();
        t_erase();
        expect_page(1, 100, "R8 offset load data");
        t_ce();
        t_done();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule